// File: doc/BRIEF.md
# Product-Term Array with Steering Allocator

This block is the combinational heart of one logic block in a programmable logic fabric. Each of 36 routed signals is offered to an AND plane in both true and inverted form, so the plane has 72 columns. A configurable connection bitmap selects the literals of each of 86 product terms. A second bitmap then steers terms into 16 sum outputs. Each sum is the OR of the terms routed to it, and a single term may drive any number of sums at once.

The configuration is held twice. A staging chain is filled one bit per cycle through a serial port. A commit strobe copies it into the active copy, which drives the logic, so the outputs never see a half-loaded pattern. On a commit, a small loader state machine checks the staged allocator bitmap. It refuses any pattern that routes more than 16 terms to one sum, raises an error flag and leaves the active configuration as it was.

The loader has four states. ST_IDLE accepts shift cycles and leaves on a commit strobe (IDLE→CHECK). ST_CHECK counts the terms in each staged sum row for one cycle and moves to ST_COMMIT when every row is within the limit (CHECK→COMMIT), or to ST_REJECT when any row is over it (CHECK→REJECT). ST_COMMIT copies the staging chain into the active copy and clears the error flag. ST_REJECT sets the error flag. Both return to ST_IDLE unconditionally (COMMIT→IDLE, REJECT→IDLE).

Top module: `pterm_steer_core`

## Requirements
- R1: Input i feeds AND-plane column 2i in true form and column 2i+1 in inverted form. In the flat configuration word, bit MAP_W + t*72 + c connects column c to product term t, where MAP_W = 86*16.
- R2: A product term is the AND of its connected literals, and a term with no connected literals is 1.
- R3: A product term that connects both the true and the inverted column of the same input is 0 for every input value.
- R4: Sum output s is the OR of every term t whose allocator bit s*86 + t is set, and a sum with no routed terms is 0.
- R5: One product term routed to several sums drives all of them at the same time.
- R6: A sum row with exactly 16 routed terms is accepted, and cfg_err is cleared.
- R7: A commit whose staged pattern routes more than 16 terms to any sum is rejected: cfg_err goes to 1 and all outputs keep the previous configuration. A later accepted commit clears cfg_err.
- R8: The configuration word is shifted in most significant bit first, one bit per cycle while cfg_shift is high. Shifting alone leaves the outputs unchanged. cfg_busy is high from the first edge after a commit strobe, and the new configuration drives sum_out after the second edge following that one.
- R9: cfg_shift and cfg_commit have no effect while cfg_busy is high.
- R10: After reset the active configuration is all zero, so sum_out is 0, and cfg_busy and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration logic |
| rst_n | input | 1 | Active-low synchronous reset |
| route_in | input | 36 | Signals arriving from the routing matrix |
| cfg_sdi | input | 1 | Serial configuration data, MSB first |
| cfg_shift | input | 1 | Shifts cfg_sdi into the staging chain |
| cfg_commit | input | 1 | Requests validation and activation of the staged word |
| sum_out | output | 16 | Combinational sum outputs to the macrocells |
| cfg_busy | output | 1 | Loader is validating or applying a commit |
| cfg_err | output | 1 | Last commit was refused for exceeding the term limit |

## Verification
Any corrupted bit in the active copy shows at once in sum_out, but only for input patterns that make the affected term decide a sum. For this reason the vector table drives patterns that toggle each used term, including the constant-one and constant-zero terms. A loader that lost or shifted staged bits would only show after the next commit, two cycles after the strobe. A replayed commit after an attempted shift during cfg_busy is used to expose this. A faulty limit check shows in the same cycle window as a wrong cfg_err, or as sums that change when they should have stayed frozen.

// File: rtl/pts_pkg.sv
package pts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_REJECT = 2'd3
    } ld_state_t;
endpackage

// File: rtl/pts_cfg_loader.sv
module pts_cfg_loader
    import pts_pkg::*;
#(
    parameter int N_IN      = 36,
    parameter int N_PT      = 86,
    parameter int N_SUM     = 16,
    parameter int MAX_TERMS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sdi,
    input  logic                      shift_en,
    input  logic                      commit,
    output logic [2*N_IN*N_PT-1:0]    and_cfg,
    output logic [N_PT*N_SUM-1:0]     map_cfg,
    output logic                      busy,
    output logic                      err
);
    localparam int AND_W = 2 * N_IN * N_PT;
    localparam int MAP_W = N_PT * N_SUM;
    localparam int CFG_W = AND_W + MAP_W;
    localparam int CNT_W = $clog2(N_PT + 1);

    ld_state_t          st, st_nx;
    logic [CFG_W-1:0]   stage;
    logic [CFG_W-1:0]   active;
    logic [N_SUM-1:0]   row_over;

    function automatic logic [CNT_W-1:0] popc(input logic [N_PT-1:0] v);
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < N_PT; k++) acc = acc + CNT_W'(v[k]);
        return acc;
    endfunction

    for (genvar s = 0; s < N_SUM; s++) begin : g_row
        assign row_over[s] = int'(popc(stage[s*N_PT +: N_PT])) > MAX_TERMS;

        AST_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(active[s*N_PT +: N_PT]) <= MAX_TERMS); // R7
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   st_nx = commit ? ST_CHECK : ST_IDLE;
            ST_CHECK:  st_nx = (|row_over) ? ST_REJECT : ST_COMMIT;
            ST_COMMIT: st_nx = ST_IDLE;
            ST_REJECT: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage  <= '0;
            active <= '0;
            err    <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE:   if (shift_en) stage <= {stage[CFG_W-2:0], sdi};
                ST_CHECK:  ;
                ST_COMMIT: begin
                    active <= stage;
                    err    <= 1'b0;
                end
                ST_REJECT: err <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign and_cfg = active[CFG_W-1:MAP_W];
    assign map_cfg = active[MAP_W-1:0];

    AST_CHECK_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK) |=> (st == ST_COMMIT || st == ST_REJECT)); // R8

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REJECT) |=> ($stable(active) && err)); // R7

    AST_BUSY_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(stage)); // R9
endmodule

// File: rtl/pts_and_plane.sv
module pts_and_plane #(
    parameter int N_IN = 36,
    parameter int N_PT = 86
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        route_in,
    input  logic [2*N_IN*N_PT-1:0] and_cfg,
    output logic [N_PT-1:0]        pterm
);
    localparam int COLS = 2 * N_IN;

    logic [COLS-1:0] lit;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = route_in[i];
        assign lit[2*i+1] = ~route_in[i];
    end

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [N_IN-1:0] both;

        assign pterm[t] = &(lit | ~and_cfg[t*COLS +: COLS]);

        for (genvar i = 0; i < N_IN; i++) begin : g_pair
            assign both[i] = and_cfg[t*COLS + 2*i] & and_cfg[t*COLS + 2*i + 1];
        end

        AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (|both) |-> !pterm[t]); // R3
    end
endmodule

// File: rtl/pts_or_alloc.sv
module pts_or_alloc #(
    parameter int N_PT  = 86,
    parameter int N_SUM = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PT-1:0]       pterm,
    input  logic [N_PT*N_SUM-1:0] map_cfg,
    output logic [N_SUM-1:0]      sum_out
);
    for (genvar s = 0; s < N_SUM; s++) begin : g_sum
        assign sum_out[s] = |(pterm & map_cfg[s*N_PT +: N_PT]);

        AST_EMPTY_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (map_cfg[s*N_PT +: N_PT] == '0) |-> !sum_out[s]); // R4
    end
endmodule

// File: rtl/pterm_steer_core.sv
module pterm_steer_core #(
    parameter int N_IN      = 36,
    parameter int N_PT      = 86,
    parameter int N_SUM     = 16,
    parameter int MAX_TERMS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  route_in,
    input  logic             cfg_sdi,
    input  logic             cfg_shift,
    input  logic             cfg_commit,
    output logic [N_SUM-1:0] sum_out,
    output logic             cfg_busy,
    output logic             cfg_err
);
    localparam int AND_W = 2 * N_IN * N_PT;
    localparam int MAP_W = N_PT * N_SUM;

    logic [AND_W-1:0] and_cfg;
    logic [MAP_W-1:0] map_cfg;
    logic [N_PT-1:0]  pterm;

    pts_cfg_loader #(
        .N_IN(N_IN), .N_PT(N_PT), .N_SUM(N_SUM), .MAX_TERMS(MAX_TERMS)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .sdi(cfg_sdi), .shift_en(cfg_shift),
        .commit(cfg_commit), .and_cfg(and_cfg), .map_cfg(map_cfg),
        .busy(cfg_busy), .err(cfg_err)
    );

    pts_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .clk(clk), .rst_n(rst_n), .route_in(route_in),
        .and_cfg(and_cfg), .pterm(pterm)
    );

    pts_or_alloc #(.N_PT(N_PT), .N_SUM(N_SUM)) u_or (
        .clk(clk), .rst_n(rst_n), .pterm(pterm),
        .map_cfg(map_cfg), .sum_out(sum_out)
    );
endmodule

// File: tb/tb_pterm_steer_core.sv
module tb_pterm_steer_core;
    localparam int NI    = 36;
    localparam int NP    = 86;
    localparam int NS    = 16;
    localparam int MAP_W = NP * NS;
    localparam int CFG_W = 2 * NI * NP + MAP_W;
    localparam int NVEC  = 7;

    localparam logic [NI-1:0] VEC_IN [NVEC] = '{
        36'h0, 36'h3, 36'h8_0000_0000, 36'hC_0000_0001,
        36'hF_FFFF_FFFF, 36'h6, 36'h8_0000_0001
    };
    localparam logic [NS-1:0] VEC_EXP [NVEC] = '{
        16'h002C, 16'h800B, 16'h002E, 16'h0008,
        16'h800B, 16'h002C, 16'h002A
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0] route_in = '0;
    logic cfg_sdi = 1'b0, cfg_shift = 1'b0, cfg_commit = 1'b0;
    logic [NS-1:0] sum_out;
    logic cfg_busy, cfg_err;
    logic [CFG_W-1:0] cfg;
    logic busy_seen;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pterm_steer_core dut (
        .clk(clk), .rst_n(rst_n), .route_in(route_in), .cfg_sdi(cfg_sdi),
        .cfg_shift(cfg_shift), .cfg_commit(cfg_commit), .sum_out(sum_out),
        .cfg_busy(cfg_busy), .cfg_err(cfg_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic lit(int t, int i, int comp);
        cfg[MAP_W + t*2*NI + 2*i + comp] = 1'b1;
    endtask

    task automatic route(int s, int t);
        cfg[s*NP + t] = 1'b1;
    endtask

    task automatic build_a();
        cfg = '0;
        lit(0, 0, 0); lit(0, 1, 0);
        lit(1, 0, 1);
        lit(3, 35, 0); lit(3, 34, 1);
        lit(4, 2, 0); lit(4, 2, 1);
        route(0, 0); route(1, 0); route(1, 3); route(2, 1); route(3, 2);
        route(4, 4); route(5, 3); route(5, 1); route(15, 0);
    endtask

    task automatic build_b();
        build_a();
        for (int k = 0; k < 16; k++) begin
            lit(10 + k, k, 0);
            route(7, 10 + k);
        end
    endtask

    task automatic load_cfg();
        for (int i = CFG_W - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_sdi   = cfg[i];
            cfg_shift = 1'b1;
        end
        @(negedge clk);
        cfg_shift = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk) cfg_commit = 1'b1;
        @(negedge clk) cfg_commit = 1'b0;
        busy_seen = cfg_busy;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic apply_in(logic [NI-1:0] v);
        @(negedge clk) route_in = v;
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply_in(36'hF_FFFF_FFFF);
        chk("R10 sum_out after reset", 32'(sum_out), 32'h0);
        chk("R10 busy after reset", 32'(cfg_busy), 32'h0);
        chk("R10 err after reset", 32'(cfg_err), 32'h0);

        build_a();
        load_cfg();
        apply_in(36'h0);
        chk("R8 shifted but not committed", 32'(sum_out), 32'h0);
        do_commit();
        chk("R8 busy after commit edge", 32'(busy_seen), 32'h1);
        chk("R8 idle after apply", 32'(cfg_busy), 32'h0);

        // R1 R2 R3 R4 R5: vector table over configuration A
        for (int v = 0; v < NVEC; v++) begin
            apply_in(VEC_IN[v]);
            chk("R1/R2/R3/R4/R5 vector", 32'(sum_out), 32'(VEC_EXP[v]));
        end

        build_b();
        load_cfg();
        do_commit();
        chk("R6 sixteen-term row accepted", 32'(cfg_err), 32'h0);
        apply_in(36'h0_0000_8000);
        chk("R6 sixteen-term sum", 32'(sum_out), 32'h00AC);
        apply_in(36'hF_FFFF_FFFF);
        chk("R6 all ones", 32'(sum_out), 32'h808B);

        build_b();
        for (int k = 0; k < 17; k++) route(8, 10 + k);
        load_cfg();
        do_commit();
        chk("R7 over-limit flags error", 32'(cfg_err), 32'h1);
        apply_in(36'h0_0000_8000);
        chk("R7 previous config kept", 32'(sum_out), 32'h00AC);
        apply_in(36'h0);
        chk("R7 previous config kept, zero in", 32'(sum_out), 32'h002C);

        build_b();
        load_cfg();
        do_commit();
        chk("R7 accepted commit clears error", 32'(cfg_err), 32'h0);

        // R9: shift and commit while busy must not disturb staging
        @(negedge clk) cfg_commit = 1'b1;
        @(negedge clk);
        chk("R9 busy during check", 32'(cfg_busy), 32'h1);
        cfg_shift = 1'b1; cfg_sdi = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0; cfg_shift = 1'b0; cfg_sdi = 1'b0;
        repeat (3) @(negedge clk);
        do_commit();
        apply_in(36'h0_0000_8000);
        chk("R9 staging untouched while busy", 32'(sum_out), 32'h00AC);
        chk("R9 no error after replay", 32'(cfg_err), 32'h0);

        finish_run();
    end
endmodule